// File: doc/BRIEF.md
# Two-Bank SDRAM Command Decoder and Bank Tracker

This block is the control front end on the device side of a two-bank synchronous DRAM. At every rising clock edge it samples the command strobes (chip select, row strobe, column strobe, write enable), the clock enable for the current cycle and the clock enable registered from the previous cycle, the bank select and a nine-bit address. From these it forms a single command. It keeps a small state machine for each bank (idle, open with a stored row, or bursting), a mode register, a shared burst-beat counter and a self-refresh flag.

The data path and the array control take registered strobes from this block. A pulse marks each accepted read or write and carries the column that was latched with it. Another pulse marks any command the block refuses because the current state does not allow it. A refused command changes no state. Address bit 8 has two uses. On a read or write it requests precharge after the last beat. On a precharge it closes both banks.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: One cycle after each edge, `cmd_code` shows the command sampled at that edge: 0 for no-op or deselect (chip select high), 1 ACT (row low, column and write high), 2 READ (column low only), 3 WRITE (column and write low, row high), 4 PRE (row and write low, A8 low), 5 precharge-all (same pins with A8 high), 6 auto-refresh (row and column low, write high, clock enable high), 7 self-refresh entry (same pins with clock enable low), 8 mode set (all three low), 9 burst stop (write low only).
- R2: When clock enable was low at the previous edge, the command sampled at the current edge is ignored. `cmd_code` reads 0, no strobe or illegal pulse is raised, and no state changes.
- R3: ACT to an idle bank opens that bank and stores A0-A8 as its row in `row_bus` (bank b uses bits 9b+8 down to 9b).
- R4: READ or WRITE to an open bank pulses `rd_stb` or `wr_stb` for one cycle and latches A0-A7 into `col_out`. The bank then reads as bursting for as many cycles as the burst length, and after that it reads as open again.
- R5: A8 high on READ or WRITE sets `ap_pend` for that bank. At the last burst beat the bank returns to idle and the flag clears.
- R6: PRE with A8 low closes only the selected bank. PRE with A8 high closes both banks. Either form ends a burst in a bank it closes.
- R7: Burst stop ends the running burst and leaves its bank open. A READ or WRITE to the other bank also ends it and starts the new burst there.
- R8: With burst length code 111 (full page) a burst runs until something terminates it. A READ or WRITE with A8 high under that burst length is illegal.
- R9: The following raise `illegal` for one cycle and change no state: ACT to a bank that is not idle, READ or WRITE to an idle bank, and auto-refresh or self-refresh entry while any bank is not idle.
- R10: A legal self-refresh entry sets `self_ref`. `self_ref` falls as soon as clock enable goes high, with no clock edge needed. The command at the edge where clock enable returns is ignored.
- R11: Mode set loads burst length from A2-A0 (000=1, 001=2, 010=4, 011=8, 111=full page), interleave from A3 and CAS latency from A6-A4 (1 to 3). The mode set is illegal and leaves the mode unchanged if A7 is high, if a code is reserved, or if any bank is not idle.
- R12: At most one bank reads as bursting at any time.
- R13: After reset both banks are idle, all strobes are low, `self_ref` is low, and the mode is burst length 1, sequential, CAS latency 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | BA_W | Bank select |
| addr | input | ROW_W | Address A0-A8 |
| cmd_code | output | 4 | Command accepted at the last edge |
| rd_stb | output | 1 | Legal read accepted |
| wr_stb | output | 1 | Legal write accepted |
| illegal | output | 1 | Command refused |
| col_out | output | COL_W | Column of the last accepted read or write |
| bank_open | output | NB | Bank is not idle |
| bank_burst | output | NB | Bank is bursting |
| ap_pend | output | NB | Auto-precharge is pending |
| row_bus | output | NB*ROW_W | Stored row of each bank |
| self_ref | output | 1 | In self-refresh |
| mode_bl | output | 3 | Burst length code |
| mode_ilv | output | 1 | Interleave burst order |
| mode_cl | output | 3 | CAS latency |

## Verification
The bench uses the default parameters: a 9-bit row, an 8-bit column and one bank-select bit, which gives two banks. With these values every per-bank interaction between the two banks can be tested: a burst handed from one bank to the other, precharge of one bank versus both, and illegal ACT, READ and refresh against a mix of open and idle banks. The full-page mode is exercised by holding a burst for twenty cycles and then terminating it. Self-refresh exit is checked between clock edges to show that it does not wait for a clock edge.

// File: rtl/sdram_ctl_pkg.sv
package sdram_ctl_pkg;
  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_ACT  = 4'd1,
    CMD_RD   = 4'd2,
    CMD_WR   = 4'd3,
    CMD_PRE  = 4'd4,
    CMD_PREA = 4'd5,
    CMD_REFA = 4'd6,
    CMD_REFS = 4'd7,
    CMD_MRS  = 4'd8,
    CMD_BST  = 4'd9
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE  = 2'd0,
    BK_OPEN  = 2'd1,
    BK_BURST = 2'd2
  } bank_st_e;

  typedef struct packed {
    logic [2:0] cl;
    logic       ilv;
    logic [2:0] bl;
  } mode_t;

  localparam logic [2:0] BL_FULL    = 3'b111;
  localparam logic [2:0] CL_DEFAULT = 3'd2;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_ctl_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic cke,
  input  logic cke_prev,
  input  logic a8,
  output cmd_e cmd
);
  always_comb begin
    cmd = CMD_NOP;
    if (cke_prev && !cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b111: cmd = CMD_NOP;
        3'b011: cmd = CMD_ACT;
        3'b101: cmd = CMD_RD;
        3'b100: cmd = CMD_WR;
        3'b010: cmd = a8 ? CMD_PREA : CMD_PRE;
        3'b001: cmd = cke ? CMD_REFA : CMD_REFS;
        3'b000: cmd = CMD_MRS;
        3'b110: cmd = CMD_BST;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
  import sdram_ctl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  mode_t din,
  output logic  fields_ok,
  output mode_t mode
);
  mode_t mode_q, mode_d;
  logic  bl_ok, cl_ok;

  always_comb begin
    bl_ok = (din.bl[2] == 1'b0) || (din.bl == BL_FULL);
    cl_ok = (din.cl != 3'd0) && (din.cl <= 3'd3);
    fields_ok = bl_ok && cl_ok;
  end

  always_comb begin
    mode_d = mode_q;
    if (load) mode_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '{cl: CL_DEFAULT, ilv: 1'b0, bl: 3'b000};
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;

  assert_cl_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.cl != 3'd0) && (mode_q.cl <= 3'd3));
endmodule

// File: rtl/sdram_burst_ctr.sv
module sdram_burst_ctr #(
  parameter int COL_W = 8,
  parameter int BA_W  = 1,
  localparam int CNT_W = COL_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start,
  input  logic [BA_W-1:0]  start_bank,
  input  logic             full_page,
  input  logic [CNT_W-1:0] len,
  input  logic             stop,
  output logic             busy,
  output logic [BA_W-1:0]  cur_bank,
  output logic             last
);
  logic             busy_q, busy_d, fp_q, fp_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic [BA_W-1:0]  bank_q, bank_d;

  always_comb begin
    last = en && busy_q && !fp_q && (left_q == CNT_W'(1));
  end

  always_comb begin
    busy_d = busy_q;
    fp_d   = fp_q;
    left_d = left_q;
    bank_d = bank_q;
    if (en) begin
      if (start) begin
        busy_d = 1'b1;
        fp_d   = full_page;
        left_d = len;
        bank_d = start_bank;
      end else if (stop) begin
        busy_d = 1'b0;
      end else if (busy_q && !fp_q) begin
        left_d = left_q - CNT_W'(1);
        if (left_q == CNT_W'(1)) busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      fp_q   <= 1'b0;
      left_q <= '0;
      bank_q <= '0;
    end else begin
      busy_q <= busy_d;
      fp_q   <= fp_d;
      left_q <= left_d;
      bank_q <= bank_d;
    end
  end

  assign busy     = busy_q;
  assign cur_bank = bank_q;

  assert_count_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fp_q) |-> (left_q != '0));
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_ctl_pkg::*;
#(
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             open_i,
  input  logic             rw_i,
  input  logic             ap_i,
  input  logic             close_i,
  input  logic             leave_i,
  input  logic [ROW_W-1:0] row_in,
  output bank_st_e         state,
  output logic [ROW_W-1:0] row,
  output logic             ap_pend
);
  bank_st_e         st_q, st_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             ap_q, ap_d;

  always_comb begin
    st_d  = st_q;
    row_d = row_q;
    ap_d  = ap_q;
    if (en) begin
      if (close_i) begin
        st_d = BK_IDLE;
        ap_d = 1'b0;
      end else if (open_i) begin
        st_d  = BK_OPEN;
        row_d = row_in;
      end else if (rw_i) begin
        st_d = BK_BURST;
        ap_d = ap_i;
      end else if (leave_i) begin
        st_d = ap_q ? BK_IDLE : BK_OPEN;
        ap_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BK_IDLE;
      row_q <= '0;
      ap_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      row_q <= row_d;
      ap_q  <= ap_d;
    end
  end

  assign state   = st_q;
  assign row     = row_q;
  assign ap_pend = ap_q;

  assert_ap_only_in_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ap_q |-> (st_q == BK_BURST));
  assert_act_from_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && open_i && !close_i) |-> (st_q == BK_IDLE));
endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_ctl_pkg::*;
#(
  parameter int ROW_W = 9,
  parameter int COL_W = 8,
  parameter int BA_W  = 1,
  localparam int NB    = 1 << BA_W,
  localparam int CNT_W = COL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              cke,
  input  logic [BA_W-1:0]   ba,
  input  logic [ROW_W-1:0]  addr,
  output logic [3:0]        cmd_code,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic              illegal,
  output logic [COL_W-1:0]  col_out,
  output logic [NB-1:0]     bank_open,
  output logic [NB-1:0]     bank_burst,
  output logic [NB-1:0]     ap_pend,
  output logic [NB*ROW_W-1:0] row_bus,
  output logic              self_ref,
  output logic [2:0]        mode_bl,
  output logic              mode_ilv,
  output logic [2:0]        mode_cl
);
  logic cke_prev_q;
  logic sr_q, sr_d;
  logic en;
  cmd_e cmd;

  bank_st_e bk_st [NB];
  logic     any_open, sel_idle, is_rw, fp_mode;
  logic     act_ok, rw_ok, ref_ok, mrs_ok, ill_now;
  logic     mode_fields_ok, stop_burst, burst_busy, burst_last;
  logic [BA_W-1:0]  burst_bank;
  logic [CNT_W-1:0] burst_len;
  mode_t    mode;

  logic [3:0]       cmd_q;
  logic             rd_q, wr_q, ill_q;
  logic [COL_W-1:0] col_q, col_d;

  assign en = cke_prev_q;

  sdram_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cke(cke), .cke_prev(cke_prev_q), .a8(addr[8]), .cmd(cmd)
  );

  sdram_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .load(mrs_ok),
    .din('{cl: addr[6:4], ilv: addr[3], bl: addr[2:0]}),
    .fields_ok(mode_fields_ok), .mode(mode)
  );

  always_comb begin
    any_open = 1'b0;
    for (int b = 0; b < NB; b++) any_open |= (bk_st[b] != BK_IDLE);
    sel_idle = (bk_st[ba] == BK_IDLE);
    is_rw    = (cmd == CMD_RD) || (cmd == CMD_WR);
    fp_mode  = (mode.bl == BL_FULL);
    act_ok   = (cmd == CMD_ACT) && sel_idle;
    rw_ok    = is_rw && !sel_idle && !(addr[8] && fp_mode);
    ref_ok   = ((cmd == CMD_REFA) || (cmd == CMD_REFS)) && !any_open;
    mrs_ok   = (cmd == CMD_MRS) && !addr[7] && mode_fields_ok && !any_open;
    ill_now  = ((cmd == CMD_ACT) && !act_ok) || (is_rw && !rw_ok) ||
               (((cmd == CMD_REFA) || (cmd == CMD_REFS)) && !ref_ok) ||
               ((cmd == CMD_MRS) && !mrs_ok);
    stop_burst = (cmd == CMD_BST) || (cmd == CMD_PREA) ||
                 ((cmd == CMD_PRE) && (ba == burst_bank));
    burst_len  = CNT_W'(1) << mode.bl[1:0];
  end

  sdram_burst_ctr #(.COL_W(COL_W), .BA_W(BA_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .en(en), .start(rw_ok), .start_bank(ba),
    .full_page(fp_mode), .len(burst_len), .stop(stop_burst),
    .busy(burst_busy), .cur_bank(burst_bank), .last(burst_last)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic open_b, rw_b, close_b, leave_b;
    logic [ROW_W-1:0] row_b;
    logic ap_b;
    always_comb begin
      open_b  = act_ok && (ba == BA_W'(b));
      rw_b    = rw_ok && (ba == BA_W'(b));
      close_b = (cmd == CMD_PREA) || ((cmd == CMD_PRE) && (ba == BA_W'(b)));
      leave_b = (bk_st[b] == BK_BURST) &&
                (burst_last || (cmd == CMD_BST) || (rw_ok && (ba != BA_W'(b))));
    end
    sdram_bank_track #(.ROW_W(ROW_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .en(en), .open_i(open_b), .rw_i(rw_b),
      .ap_i(addr[8]), .close_i(close_b), .leave_i(leave_b), .row_in(addr),
      .state(bk_st[b]), .row(row_b), .ap_pend(ap_b)
    );
    assign row_bus[b*ROW_W +: ROW_W] = row_b;
    assign ap_pend[b]    = ap_b;
    assign bank_open[b]  = (bk_st[b] != BK_IDLE);
    assign bank_burst[b] = (bk_st[b] == BK_BURST);
  end

  always_comb begin
    sr_d = sr_q;
    if (sr_q && cke)                           sr_d = 1'b0;
    else if (en && (cmd == CMD_REFS) && ref_ok) sr_d = 1'b1;
    col_d = col_q;
    if (en && rw_ok) col_d = addr[COL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_prev_q <= 1'b0;
      sr_q       <= 1'b0;
      cmd_q      <= 4'd0;
      rd_q       <= 1'b0;
      wr_q       <= 1'b0;
      ill_q      <= 1'b0;
      col_q      <= '0;
    end else begin
      cke_prev_q <= cke;
      sr_q       <= sr_d;
      cmd_q      <= cmd;
      rd_q       <= rw_ok && (cmd == CMD_RD);
      wr_q       <= rw_ok && (cmd == CMD_WR);
      ill_q      <= ill_now;
      col_q      <= col_d;
    end
  end

  assign self_ref = sr_q && !cke;
  assign cmd_code = cmd_q;
  assign rd_stb   = rd_q;
  assign wr_stb   = wr_q;
  assign illegal  = ill_q;
  assign col_out  = col_q;
  assign mode_bl  = mode.bl;
  assign mode_ilv = mode.ilv;
  assign mode_cl  = mode.cl;

  assert_one_burst_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_burst));
  assert_strobe_bursts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |-> (bank_burst != '0));
  assert_suspended_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_prev_q |=> ((cmd_code == 4'd0) && !illegal && !rd_stb && !wr_stb));
  assert_sr_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sr_q |-> (!rd_stb && !wr_stb && (bank_open == '0)));
endmodule

// File: tb/tb_sdram_cmd_ctrl.sv
module tb_sdram_cmd_ctrl;
  localparam logic [2:0] P_NOP = 3'b111, P_ACT = 3'b011, P_RD = 3'b101,
    P_WR = 3'b100, P_PRE = 3'b010, P_REF = 3'b001, P_MRS = 3'b000, P_BST = 3'b110;

  logic clk, rst_n, cs_n, ras_n, cas_n, we_n, cke;
  logic [0:0] ba;
  logic [8:0] addr;
  logic [3:0] cmd_code;
  logic rd_stb, wr_stb, illegal, self_ref, mode_ilv;
  logic [7:0] col_out;
  logic [1:0] bank_open, bank_burst, ap_pend;
  logic [17:0] row_bus;
  logic [2:0] mode_bl, mode_cl;
  int checks = 0, failures = 0;

  sdram_cmd_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .cmd_code(cmd_code),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .illegal(illegal), .col_out(col_out),
    .bank_open(bank_open), .bank_burst(bank_burst), .ap_pend(ap_pend),
    .row_bus(row_bus), .self_ref(self_ref), .mode_bl(mode_bl),
    .mode_ilv(mode_ilv), .mode_cl(mode_cl)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] pins, input logic b, input logic [8:0] a);
    cs_n = 1'b0;
    {ras_n, cas_n, we_n} = pins;
    ba = b;
    addr = a;
  endtask

  task automatic issue(input logic [2:0] pins, input logic b, input logic [8:0] a);
    drive(pins, b, a);
    @(posedge clk);
    @(negedge clk);
    drive(P_NOP, 1'b0, 9'h0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R13 cmd", cmd_code, 0);
    chk("R13 banks", {bank_open, bank_burst, ap_pend}, 0);
    chk("R13 strobes", {rd_stb, wr_stb, illegal, self_ref}, 0);
    chk("R13 mode", {mode_cl, mode_ilv, mode_bl}, {3'd2, 1'b0, 3'b000});
  endtask

  task automatic t_decode_mode;
    cs_n = 1'b1; {ras_n, cas_n, we_n} = P_ACT;
    @(posedge clk); @(negedge clk);
    chk("R1 deselect", {cmd_code, bank_open}, 0);
    issue(P_MRS, 1'b0, 9'h032);
    chk("R1 mrs code", cmd_code, 8);
    chk("R11 mode load", {mode_cl, mode_ilv, mode_bl}, {3'd3, 1'b0, 3'b010});
    issue(P_MRS, 1'b0, 9'h0A3);
    chk("R11 a7 illegal", illegal, 1);
    chk("R11 mode kept", {mode_cl, mode_ilv, mode_bl}, {3'd3, 1'b0, 3'b010});
    issue(P_MRS, 1'b0, 9'h015);
    chk("R11 reserved bl", {illegal, mode_bl}, {1'b1, 3'b010});
  endtask

  task automatic t_read_burst;
    issue(P_ACT, 1'b0, 9'h1A5);
    chk("R1 act code", cmd_code, 1);
    chk("R3 open", bank_open, 2'b01);
    chk("R3 row", row_bus[8:0], 9'h1A5);
    issue(P_RD, 1'b0, 9'h03C);
    chk("R1 rd code", cmd_code, 2);
    chk("R4 rd strobe", {rd_stb, wr_stb}, 2'b10);
    chk("R4 col", col_out, 8'h3C);
    chk("R4 bursting", bank_burst, 2'b01);
    idle(1);
    chk("R4 strobe pulse", rd_stb, 0);
    idle(2);
    chk("R4 still bursting", bank_burst, 2'b01);
    idle(1);
    chk("R4 burst over", {bank_burst, bank_open}, {2'b00, 2'b01});
  endtask

  task automatic t_autopre;
    issue(P_WR, 1'b0, 9'h111);
    chk("R1 wr code", cmd_code, 3);
    chk("R5 wr strobe", {wr_stb, ap_pend}, {1'b1, 2'b01});
    idle(3);
    chk("R5 pending", {ap_pend, bank_open}, {2'b01, 2'b01});
    idle(1);
    chk("R5 closed", {ap_pend, bank_open}, 0);
  endtask

  task automatic t_illegal;
    issue(P_RD, 1'b1, 9'h005);
    chk("R9 rd idle", {illegal, rd_stb, bank_burst}, {1'b1, 1'b0, 2'b00});
    issue(P_ACT, 1'b1, 9'h005);
    chk("R9 act ok", {illegal, bank_open}, {1'b0, 2'b10});
    issue(P_ACT, 1'b1, 9'h007);
    chk("R9 act open", {illegal, row_bus[17:9]}, {1'b1, 9'h005});
    issue(P_REF, 1'b0, 9'h000);
    chk("R9 refa open", {cmd_code, illegal, bank_open}, {4'd6, 1'b1, 2'b10});
    issue(P_MRS, 1'b0, 9'h011);
    chk("R11 mrs open", {illegal, mode_bl}, {1'b1, 3'b010});
  endtask

  task automatic t_precharge;
    issue(P_ACT, 1'b0, 9'h0F0);
    issue(P_PRE, 1'b0, 9'h000);
    chk("R6 single", {cmd_code, bank_open}, {4'd4, 2'b10});
    issue(P_ACT, 1'b0, 9'h0F1);
    issue(P_PRE, 1'b0, 9'h100);
    chk("R6 all", {cmd_code, bank_open}, {4'd5, 2'b00});
  endtask

  task automatic t_terminate;
    issue(P_ACT, 1'b0, 9'h010);
    issue(P_RD, 1'b0, 9'h020);
    issue(P_BST, 1'b0, 9'h000);
    chk("R7 bst", {cmd_code, bank_burst, bank_open}, {4'd9, 2'b00, 2'b01});
    issue(P_ACT, 1'b1, 9'h030);
    issue(P_RD, 1'b0, 9'h040);
    issue(P_WR, 1'b1, 9'h050);
    chk("R7 handover", {bank_burst, bank_open}, {2'b10, 2'b11});
    issue(P_PRE, 1'b1, 9'h000);
    chk("R6 ends burst", {bank_burst, bank_open}, {2'b00, 2'b01});
    issue(P_PRE, 1'b0, 9'h100);
  endtask

  task automatic t_full_page;
    issue(P_MRS, 1'b0, 9'h027);
    chk("R8 fp mode", {mode_cl, mode_bl}, {3'd2, 3'b111});
    issue(P_ACT, 1'b0, 9'h002);
    issue(P_RD, 1'b0, 9'h000);
    idle(20);
    chk("R8 runs on", bank_burst, 2'b01);
    issue(P_RD, 1'b0, 9'h104);
    chk("R8 ap illegal", {illegal, rd_stb, ap_pend, bank_burst}, {1'b1, 1'b0, 2'b00, 2'b01});
    issue(P_PRE, 1'b0, 9'h100);
    chk("R8 stopped", {bank_burst, bank_open}, 0);
  endtask

  task automatic t_suspend;
    cke = 1'b0;
    @(posedge clk); @(negedge clk);
    cke = 1'b1;
    issue(P_ACT, 1'b0, 9'h055);
    chk("R2 ignored", {cmd_code, illegal, bank_open}, 0);
    idle(1);
  endtask

  task automatic t_self_refresh;
    issue(P_REF, 1'b0, 9'h000);
    chk("R1 refa code", {cmd_code, illegal, self_ref}, {4'd6, 1'b0, 1'b0});
    cke = 1'b0;
    issue(P_REF, 1'b0, 9'h000);
    chk("R10 entry", {cmd_code, self_ref}, {4'd7, 1'b1});
    idle(3);
    chk("R10 held", self_ref, 1);
    drive(P_ACT, 1'b0, 9'h066);
    cke = 1'b1;
    #1;
    chk("R10 async exit", self_ref, 0);
    @(posedge clk); @(negedge clk);
    chk("R10 exit edge ignored", {cmd_code, bank_open}, 0);
    issue(P_ACT, 1'b0, 9'h066);
    chk("R10 after exit", {cmd_code, bank_open}, {4'd1, 2'b01});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1;
    {ras_n, cas_n, we_n} = P_NOP; ba = 1'b0; addr = 9'h0;
    idle(3);
    t_reset;
    rst_n = 1'b1;
    idle(2);
    t_decode_mode;
    t_read_burst;
    t_autopre;
    t_illegal;
    t_precharge;
    t_terminate;
    t_full_page;
    t_suspend;
    t_self_refresh;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule